// File: doc/BRIEF.md
# Endpoint Transfer-Success Status Register

This block holds the transfer-success flags of two endpoints of a USB function controller in one 8-bit status register. The protocol engine reports each completed handshake as a single-cycle pulse. The pulse carries the endpoint number, the token direction, and whether the function or the host sent the ACK. When the pulse matches the completion rule of an endpoint, the flag of that endpoint is set. A flag at 0 means the endpoint is waiting for a transfer. A flag at 1 means a transfer has completed normally.

Software reads the register through a read strobe and can only clear flags, by writing 0. A write of 0 takes effect only on a flag that software has seen as 1 through a read since the flag was last set. Each flag therefore carries an arming bit. The arming bit is captured on a read strobe while the flag is 1, and it is dropped when the clear lands. If a set event arrives in the same cycle as a qualifying clear, the set wins and the arming bit is dropped. An interrupt output combines the flags with per-bit enable inputs.

Top module: `ep_xfer_status`

## Requirements
- R1: After reset both flags are 0, `reg_rdata` is 0x00 and `irq` is 0.
- R2: `reg_rdata` bit 4 is the endpoint 3 flag and bit 3 is the endpoint 2 flag. The other bits always read 0. Register state changes appear on `reg_rdata` in the cycle after the clock edge that causes them.
- R3: The endpoint 3 flag is set by a `hs_valid` pulse with `hs_ep`=3, `hs_dir`=1 (IN) and `hs_ack_by_func`=0 (ACK received from the host). An OUT pulse, or a pulse with the ACK sent by the function, leaves it unchanged.
- R4: The endpoint 2 flag is set by a `hs_valid` pulse with `hs_ep`=2 and `hs_ack_by_func`=1, with `hs_dir` either 0 (OUT) or 1 (IN). A pulse on endpoint 2 with `hs_ack_by_func`=0 leaves it unchanged.
- R5: Handshake pulses on any other endpoint number set no flag.
- R6: A `reg_wr` with a 0 in the bit of a flag clears that flag, provided a `reg_rd` strobe saw the flag as 1 after its last set.
- R7: A write of 0 to a flag that has not been read as 1 since its last set is ignored. This includes a flag that was read only while it was still 0.
- R8: Writing 1 to a flag bit has no effect. Writes to the undefined bits have no effect.
- R9: Arming is kept per bit, and a clear consumes it. After a clear, a flag that is set again needs a new read as 1 before a write of 0 can clear it.
- R10: When a set event and a qualifying clear of the same flag fall in one cycle, the flag stays 1 and its arming is dropped. A following write of 0 without a new read leaves it set.
- R11: `irq` is 1 exactly when some flag is 1 and its enable is 1. `irq_en` bit 4 enables the endpoint 3 flag and `irq_en` bit 3 enables the endpoint 2 flag. The other enable bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hs_valid | input | 1 | Single-cycle handshake-completed pulse |
| hs_ep | input | 4 | Endpoint number of the handshake |
| hs_dir | input | 1 | Token direction: 1 = IN, 0 = OUT |
| hs_ack_by_func | input | 1 | 1 = function sent the ACK, 0 = host sent it |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Register contents |
| irq_en | input | 8 | Per-bit interrupt enables |
| irq | output | 1 | Interrupt request |

## Verification
The set logic is driven with every combination of direction and ACK source on endpoints 2 and 3, and with pulses on unrelated endpoint numbers. This tells apart a decoder that checks the endpoint from one that also checks the direction and the ACK source. Clearing is tried in several orders: a write without a read, a read made before the set, a write of ones, a write that clears one bit and spares the other, and a re-set after a clear. These orders separate true read-before-clear arming from arming that is missing, global or sticky. A set that coincides with a qualifying clear shows the set-wins priority and the dropped arming. The interrupt is checked under enable masks that select each flag alone and under a mask that selects only undefined bits.

// File: rtl/ep_stat_pkg.sv
package ep_stat_pkg;
    localparam int REG_W = 8;
    localparam int EP_W  = 4;
    localparam int NFLAG = 2;

    typedef enum logic {
        DIR_OUT = 1'b0,
        DIR_IN  = 1'b1
    } dir_e;

    // Per-flag layout: register bit, endpoint number, and the accepted
    // {direction, ack_by_function} combinations as a 4-bit mask.
    localparam int         FLAG_POS    [NFLAG] = '{4, 3};
    localparam int         FLAG_EP     [NFLAG] = '{3, 2};
    localparam logic [3:0] FLAG_ACCEPT [NFLAG] = '{4'b0100, 4'b1010};

    typedef struct packed {
        logic flag;
        logic armed;
    } cell_t;
endpackage

// File: rtl/ep_hs_match.sv
module ep_hs_match #(
    parameter int         EP_W     = 4,
    parameter int         MATCH_EP = 0,
    parameter logic [3:0] ACCEPT   = 4'b0000
) (
    input  logic            valid,
    input  logic [EP_W-1:0] ep,
    input  logic            dir,
    input  logic            by_func,
    output logic            hit
);
    localparam logic [EP_W-1:0] EP_CODE = EP_W'(MATCH_EP);

    logic [1:0] combo_idx;

    always_comb begin
        combo_idx = {dir, by_func};
        hit       = valid && (ep == EP_CODE) && ACCEPT[combo_idx];
    end
endmodule

// File: rtl/ep_flag_cell.sv
module ep_flag_cell
    import ep_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic rd_stb,
    input  logic wr_stb,
    input  logic wr_bit,
    output logic flag
);
    cell_t cell_d, cell_q;
    logic  clr_ok;

    always_comb begin
        cell_d = cell_q;
        clr_ok = wr_stb && !wr_bit && cell_q.armed;
        if (rd_stb && cell_q.flag) begin
            cell_d.armed = 1'b1;
        end
        if (clr_ok) begin
            cell_d.flag  = 1'b0;
            cell_d.armed = 1'b0;
        end
        if (set_evt) begin
            cell_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cell_q <= '0;
        end else begin
            cell_q <= cell_d;
        end
    end

    assign flag = cell_q.flag;

    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> cell_q.flag);

    p_conflict_disarm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (set_evt && clr_ok) |=> (cell_q.flag && !cell_q.armed));

    p_clear_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ok && !set_evt) |=> (!cell_q.flag && !cell_q.armed));

    p_unarmed_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_q.flag && !cell_q.armed) |=> cell_q.flag);

    p_write_one_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_bit && cell_q.flag) |=> cell_q.flag);

    p_arm_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cell_q.armed |-> cell_q.flag);
endmodule

// File: rtl/ep_irq_merge.sv
module ep_irq_merge #(
    parameter int W = 2
) (
    input  logic [W-1:0] flags,
    input  logic [W-1:0] en,
    output logic         irq
);
    always_comb begin
        irq = |(flags & en);
    end
endmodule

// File: rtl/ep_xfer_status.sv
module ep_xfer_status
    import ep_stat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hs_valid,
    input  logic [EP_W-1:0]  hs_ep,
    input  logic             hs_dir,
    input  logic             hs_ack_by_func,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [REG_W-1:0] irq_en,
    output logic             irq
);
    logic [NFLAG-1:0] set_vec;
    logic [NFLAG-1:0] flag_vec;
    logic [NFLAG-1:0] en_vec;

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        ep_hs_match #(
            .EP_W     (EP_W),
            .MATCH_EP (FLAG_EP[g]),
            .ACCEPT   (FLAG_ACCEPT[g])
        ) u_match (
            .valid   (hs_valid),
            .ep      (hs_ep),
            .dir     (hs_dir),
            .by_func (hs_ack_by_func),
            .hit     (set_vec[g])
        );

        ep_flag_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_evt (set_vec[g]),
            .rd_stb  (reg_rd),
            .wr_stb  (reg_wr),
            .wr_bit  (reg_wdata[FLAG_POS[g]]),
            .flag    (flag_vec[g])
        );

        assign en_vec[g] = irq_en[FLAG_POS[g]];
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NFLAG; i++) begin
            reg_rdata[FLAG_POS[i]] = flag_vec[i];
        end
    end

    ep_irq_merge #(.W(NFLAG)) u_irq (
        .flags (flag_vec),
        .en    (en_vec),
        .irq   (irq)
    );

    p_hit_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |-> hs_valid);

    p_single_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_vec));

    p_irq_needs_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|reg_rdata));
endmodule

// File: tb/ep_xfer_status_tb.sv
module ep_xfer_status_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hs_valid = 1'b0;
    logic [3:0] hs_ep = '0;
    logic       hs_dir = 1'b0;
    logic       hs_ack_by_func = 1'b0;
    logic       reg_rd = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] irq_en = '0;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ep_xfer_status u_dut (
        .clk(clk), .rst_n(rst_n), .hs_valid(hs_valid), .hs_ep(hs_ep),
        .hs_dir(hs_dir), .hs_ack_by_func(hs_ack_by_func), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_en(irq_en), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic pulse_hs(input logic [3:0] ep, input logic dir, input logic by_func);
        hs_valid = 1'b1; hs_ep = ep; hs_dir = dir; hs_ack_by_func = by_func;
        tick();
        hs_valid = 1'b0;
    endtask

    task automatic do_read();
        reg_rd = 1'b1;
        tick();
        reg_rd = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic clear_all();
        do_read();
        do_write(8'h00);
    endtask

    task automatic t_reset();
        chk("R1 rdata after reset", reg_rdata, 8'h00);
        irq_en = 8'hFF; #1;
        chk("R1 irq after reset", {7'd0, irq}, 8'h00);
        irq_en = 8'h00;
    endtask

    task automatic t_ep3_set();
        pulse_hs(4'd3, 1'b0, 1'b0);
        chk("R3 ep3 OUT ignored", reg_rdata, 8'h00);
        pulse_hs(4'd3, 1'b1, 1'b1);
        chk("R3 ep3 func ACK ignored", reg_rdata, 8'h00);
        pulse_hs(4'd3, 1'b0, 1'b1);
        chk("R3 ep3 OUT func ACK ignored", reg_rdata, 8'h00);
        pulse_hs(4'd3, 1'b1, 1'b0);
        chk("R3 R2 ep3 IN host ACK sets bit4", reg_rdata, 8'h10);
    endtask

    task automatic t_ep2_set();
        pulse_hs(4'd2, 1'b1, 1'b0);
        chk("R4 ep2 host ACK ignored", reg_rdata, 8'h10);
        pulse_hs(4'd2, 1'b0, 1'b0);
        chk("R4 ep2 OUT host ACK ignored", reg_rdata, 8'h10);
        pulse_hs(4'd2, 1'b0, 1'b1);
        chk("R4 R2 ep2 OUT func ACK sets bit3", reg_rdata, 8'h18);
    endtask

    task automatic t_other_ep();
        clear_all();
        chk("R6 clear both", reg_rdata, 8'h00);
        foreach (ep_list[k]) begin
            pulse_hs(ep_list[k], 1'b1, 1'b0);
            pulse_hs(ep_list[k], 1'b0, 1'b1);
        end
        chk("R5 other endpoints set nothing", reg_rdata, 8'h00);
    endtask

    logic [3:0] ep_list [5] = '{4'd0, 4'd1, 4'd4, 4'd11, 4'd15};

    task automatic t_clear_rules();
        pulse_hs(4'd3, 1'b1, 1'b0);
        pulse_hs(4'd2, 1'b1, 1'b1);
        chk("R4 ep2 IN func ACK sets bit3", reg_rdata, 8'h18);
        do_write(8'h00);
        chk("R7 write 0 without read ignored", reg_rdata, 8'h18);
        do_read();
        do_write(8'hFF);
        chk("R8 write ones no effect", reg_rdata, 8'h18);
        do_write(8'hEF);
        chk("R6 R8 clear bit4 only", reg_rdata, 8'h08);
        do_write(8'h00);
        chk("R6 clear bit3 with earlier read", reg_rdata, 8'h00);
    endtask

    task automatic t_stale_read();
        do_read();
        pulse_hs(4'd3, 1'b1, 1'b0);
        do_write(8'h00);
        chk("R7 read-as-0 does not arm", reg_rdata, 8'h10);
        clear_all();
        chk("R6 clear after fresh read", reg_rdata, 8'h00);
    endtask

    task automatic t_rearm();
        pulse_hs(4'd3, 1'b1, 1'b0);
        clear_all();
        pulse_hs(4'd3, 1'b1, 1'b0);
        do_write(8'h00);
        chk("R9 re-set needs new read", reg_rdata, 8'h10);
        pulse_hs(4'd2, 1'b0, 1'b1);
        do_read();
        do_write(8'hF7);
        chk("R9 per-bit arming clears bit3", reg_rdata, 8'h10);
        clear_all();
        chk("R9 final clear", reg_rdata, 8'h00);
    endtask

    task automatic t_conflict();
        pulse_hs(4'd2, 1'b0, 1'b1);
        do_read();
        hs_valid = 1'b1; hs_ep = 4'd2; hs_dir = 1'b1; hs_ack_by_func = 1'b1;
        reg_wr = 1'b1; reg_wdata = 8'h00;
        tick();
        hs_valid = 1'b0; reg_wr = 1'b0;
        chk("R10 set wins over clear", reg_rdata, 8'h08);
        do_write(8'h00);
        chk("R10 arming dropped after conflict", reg_rdata, 8'h08);
        clear_all();
        chk("R10 clear after new read", reg_rdata, 8'h00);
    endtask

    task automatic t_irq();
        pulse_hs(4'd2, 1'b0, 1'b1);
        irq_en = 8'h00; #1;
        chk("R11 irq masked", {7'd0, irq}, 8'h00);
        irq_en = 8'h08; #1;
        chk("R11 irq from ep2", {7'd0, irq}, 8'h01);
        irq_en = 8'h10; #1;
        chk("R11 ep3 enable alone no irq", {7'd0, irq}, 8'h00);
        pulse_hs(4'd3, 1'b1, 1'b0);
        chk("R11 irq from ep3", {7'd0, irq}, 8'h01);
        irq_en = 8'hE7; #1;
        chk("R11 undefined enables ignored", {7'd0, irq}, 8'h00);
        irq_en = 8'h00;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_ep3_set();
        t_ep2_set();
        t_other_ep();
        t_clear_rules();
        t_stale_read();
        t_rearm();
        t_conflict();
        t_irq();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule